// File: doc/BRIEF.md
# Word-Parallel CRC-32 Engine with Byte Enables

This block keeps a running CRC-32 over a stream of 32-bit words, taking one word per clock. Each word is folded into the register by applying the single-bit shift-and-feedback rule once per consumed data bit, all inside one cycle. Synthesis flattens the chained steps into XOR trees. Data bits are taken from the most significant bit of the word downward. A byte-enable mask lets the last word of a frame carry fewer than four bytes.

The register is preset to all ones by reset or by a clear strobe. Frame validity is judged without a separate compare against a transmitted checksum. A frame is sent through the engine together with its appended checksum, which is the complement of the CRC, sent most significant byte first. A correct frame leaves a fixed residue in the register. A registered flag reports when the register holds that residue.

Top module: `wordcrc_engine`

## Requirements
- R1: With all four bytes enabled, one valid cycle gives the register value that results from 32 serial steps, applied in order from data bit 31 down to bit 0. Each serial step shifts the register left by one, inserting a zero. When the old bit 31 XOR the data bit is 1, the step then XORs in 32'h04C11DB7.
- R2: While reset is high at a clock edge, the register becomes 32'hFFFFFFFF and the residue flag becomes 0.
- R3: A clear strobe without valid presets the register to 32'hFFFFFFFF on the next edge and drives the residue flag low.
- R4: When valid and clear are both high in the same cycle, the data update takes effect and the clear is ignored.
- R5: Byte-enable bit 3 gates data[31:24], bit 2 gates data[23:16], bit 1 gates data[15:8] and bit 0 gates data[7:0]. For the masks 4'b1110, 4'b1100 and 4'b1000, only the enabled bytes are consumed, most significant byte first.
- R6: Valid with the mask 4'b0000 leaves the register unchanged.
- R7: With valid and clear both low, the register holds its value.
- R8: The residue flag is 1 in the cycle after an update exactly when the updated register equals 32'hC704DD7B.
- R9: Run a frame of any byte length, followed by the complement of its CRC sent most significant byte first, through the engine from the preset. The result is 32'hC704DD7B with the flag set. Flipping any single bit of that frame leaves the flag low.
- R10: For a non-contiguous mask, only the run of set bits that starts at bit 3 is consumed. For example, 4'b1011 consumes one byte and 4'b0111 consumes none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Preset the register to all ones |
| vld_i | input | 1 | Fold the enabled bytes of data_i into the register |
| data_i | input | 32 | Data word, consumed MSB first |
| be_i | input | 4 | Byte enables, bit 3 for the top byte |
| crc_o | output | 32 | Running CRC register |
| residue_ok_o | output | 1 | Register equals the good-frame residue |

## Verification
The hardest condition to reach from the ports is the residue itself. Random data almost never lands on 32'hC704DD7B, so the flag would stay dark. The bench therefore builds frames as byte streams and appends the complemented CRC computed by its own serial model. It packs the stream into words, so every frame length modulo four ends on a different partial mask. It then repeats each frame with one random bit flipped to show that the flag stays low.

// File: rtl/wordcrc_pkg.sv
package wordcrc_pkg;
  localparam int CRC_W = 32;
  typedef logic [CRC_W-1:0] crc_t;

  // One serial step: shift left, conditionally fold in the polynomial.
  function automatic crc_t crc_bit_step(input crc_t cur, input logic din, input crc_t poly);
    crc_t nxt;
    nxt = {cur[CRC_W-2:0], 1'b0};
    if (cur[CRC_W-1] ^ din) nxt = nxt ^ poly;
    return nxt;
  endfunction

  // Eight serial steps, bit 7 first.
  function automatic crc_t crc_byte_step(input crc_t cur, input logic [7:0] b, input crc_t poly);
    crc_t acc;
    acc = cur;
    for (int i = 7; i >= 0; i--) acc = crc_bit_step(acc, b[i], poly);
    return acc;
  endfunction
endpackage

// File: rtl/wordcrc_lead_count.sv
module wordcrc_lead_count #(
  parameter int NB   = 4,
  parameter int CNTW = $clog2(NB + 1)
) (
  input  logic [NB-1:0]   be_i,
  output logic [CNTW-1:0] nbytes_o
);
  // run[k] is high when bytes 0..k (counted from the top) are all enabled
  logic [NB-1:0] run;

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_run
      if (k == 0) begin : g_first
        assign run[k] = be_i[NB-1];
      end else begin : g_rest
        assign run[k] = run[k-1] & be_i[NB-1-k];
      end
    end
  endgenerate

  always_comb begin
    nbytes_o = '0;
    for (int j = 0; j < NB; j++) nbytes_o = nbytes_o + CNTW'(run[j]);
  end
endmodule

// File: rtl/wordcrc_xor_net.sv
module wordcrc_xor_net
  import wordcrc_pkg::*;
#(
  parameter crc_t POLY = 32'h04C11DB7,
  parameter int   NB   = 4,
  parameter int   CNTW = $clog2(NB + 1)
) (
  input  crc_t            crc_i,
  input  logic [NB*8-1:0] data_i,
  input  logic [CNTW-1:0] nbytes_i,
  output crc_t            crc_o
);
  // stage[k] is the register after the top k bytes have been consumed
  crc_t stage [NB+1];

  assign stage[0] = crc_i;

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_byte
      assign stage[k+1] = crc_byte_step(stage[k], data_i[(NB-k)*8-1 -: 8], POLY);
    end
  endgenerate

  assign crc_o = stage[nbytes_i];
endmodule

// File: rtl/wordcrc_engine.sv
module wordcrc_engine
  import wordcrc_pkg::*;
#(
  parameter int   DATA_W  = 32,
  parameter crc_t POLY    = 32'h04C11DB7,
  parameter crc_t INIT    = 32'hFFFFFFFF,
  parameter crc_t RESIDUE = 32'hC704DD7B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              residue_ok_o
);
  localparam int NB   = DATA_W / 8;
  localparam int CNTW = $clog2(NB + 1);

  crc_t            crc_q;
  logic            hit_q;
  logic [CNTW-1:0] nbytes;
  crc_t            crc_next;
  logic            upd_fire;
  logic            clr_fire;
  logic            next_hit;

  wordcrc_lead_count #(.NB(NB), .CNTW(CNTW)) u_count (
    .be_i     (be_i),
    .nbytes_o (nbytes)
  );

  wordcrc_xor_net #(.POLY(POLY), .NB(NB), .CNTW(CNTW)) u_net (
    .crc_i    (crc_q),
    .data_i   (data_i),
    .nbytes_i (nbytes),
    .crc_o    (crc_next)
  );

  assign upd_fire = vld_i;
  assign clr_fire = clr_i & ~vld_i;   // update wins over clear
  assign next_hit = (crc_next == RESIDUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= INIT;
      hit_q <= 1'b0;
    end else if (upd_fire) begin
      crc_q <= crc_next;
      hit_q <= next_hit;
    end else if (clr_fire) begin
      crc_q <= INIT;
      hit_q <= (INIT == RESIDUE);
    end
  end

  assign crc_o        = crc_q;
  assign residue_ok_o = hit_q;

  a_r3_clear_presets: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !vld_i) |=> (crc_o == INIT && !residue_ok_o));

  a_r6_empty_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (vld_i && be_i == '0) |=> $stable(crc_o));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!vld_i && !clr_i) |=> ($stable(crc_o) && $stable(residue_ok_o)));

  a_r8_flag_tracks_residue: assert property (@(posedge clk) disable iff (rst)
    residue_ok_o == (crc_o == RESIDUE));

  a_r10_no_lead_no_bytes: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !be_i[NB-1]) |=> $stable(crc_o));
endmodule

// File: tb/wordcrc_engine_tb_top.sv
`timescale 1ns/1ps
module wordcrc_engine_tb_top;
  localparam logic [31:0] GEN  = 32'h04C11DB7;
  localparam logic [31:0] SEED = 32'hFFFFFFFF;
  localparam logic [31:0] GOOD = 32'hC704DD7B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0;
  logic        vld_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] crc_o;
  logic        residue_ok_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model;
  logic [7:0]  fr [0:79];
  int          fr_len;

  always #10 clk = ~clk;

  wordcrc_engine dut_i (
    .clk(clk), .rst(rst), .clr_i(clr_i), .vld_i(vld_i),
    .data_i(data_i), .be_i(be_i), .crc_o(crc_o), .residue_ok_o(residue_ok_o)
  );

  // Bench model: count the leading enables, then step bit by bit.
  function automatic logic [31:0] ref_word(input logic [31:0] c, input logic [31:0] d,
                                           input logic [3:0] be);
    int n;
    logic top;
    n = 0;
    while (n < 4 && be[3-n]) n++;
    for (int b = 0; b < 8*n; b++) begin
      top = c[31];
      c = c << 1;
      if (top ^ d[31-b]) c = c ^ GEN;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_bytes(input logic [31:0] c, input int len);
    for (int i = 0; i < len; i++) c = ref_word(c, {fr[i], 24'h0}, 4'b1000);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, then compare at the following falling edge.
  task automatic cyc(input logic v, input logic c, input logic [31:0] d,
                     input logic [3:0] be, input string req);
    vld_i = v; clr_i = c; data_i = d; be_i = be;
    @(posedge clk);
    if (v) model = ref_word(model, d, be);
    else if (c) model = SEED;
    @(negedge clk);
    vld_i = 1'b0; clr_i = 1'b0;
    check(crc_o == model, req, crc_o, model);
    check(residue_ok_o == (model == GOOD), "R8", {31'b0, residue_ok_o},
          {31'b0, model == GOOD});
  endtask

  // Send fr[0..fr_len-1] packed MSB-first into words.
  task automatic send_frame(input string req);
    int k;
    logic [31:0] w;
    for (int base = 0; base < fr_len; base += 4) begin
      k = (fr_len - base < 4) ? fr_len - base : 4;
      w = '0;
      for (int j = 0; j < k; j++) w[31-8*j -: 8] = fr[base+j];
      cyc(1'b1, 1'b0, w, 4'((4'hF << (4 - k)) & 4'hF), req);
    end
  endtask

  task automatic build_good(input int msg_len);
    logic [31:0] c;
    for (int i = 0; i < msg_len; i++) fr[i] = 8'($urandom);
    c = ~ref_bytes(SEED, msg_len);
    for (int j = 0; j < 4; j++) fr[msg_len+j] = c[31-8*j -: 8];
    fr_len = msg_len + 4;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    report();
  end

  initial begin
    logic [31:0] hold;
    logic [3:0]  pats [4];
    int          pos;
    void'($urandom(32'd1234));
    pats[0] = 4'b1111; pats[1] = 4'b1110; pats[2] = 4'b1100; pats[3] = 4'b1000;
    model = SEED;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    check(crc_o == SEED, "R2", crc_o, SEED);
    check(residue_ok_o == 1'b0, "R2", {31'b0, residue_ok_o}, 32'h0);
    rst = 1'b0;

    // R1: full words, directed and random
    cyc(1'b1, 1'b0, 32'h00000000, 4'b1111, "R1");
    cyc(1'b1, 1'b0, 32'hFFFFFFFF, 4'b1111, "R1");
    cyc(1'b1, 1'b0, 32'h80000001, 4'b1111, "R1");
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, $urandom, 4'b1111, "R1");

    // R5: every legal partial mask
    for (int p = 1; p < 4; p++)
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, $urandom, pats[p], "R5");

    // R6: empty mask leaves the register alone
    hold = crc_o;
    cyc(1'b1, 1'b0, $urandom, 4'b0000, "R6");
    check(crc_o == hold, "R6", crc_o, hold);

    // R7: idle cycles
    hold = crc_o;
    cyc(1'b0, 1'b0, $urandom, 4'b1111, "R7");
    cyc(1'b0, 1'b0, $urandom, 4'b1100, "R7");
    check(crc_o == hold, "R7", crc_o, hold);

    // R10: non-contiguous masks
    cyc(1'b1, 1'b0, $urandom, 4'b1011, "R10");
    cyc(1'b1, 1'b0, $urandom, 4'b0111, "R10");
    cyc(1'b1, 1'b0, $urandom, 4'b1101, "R10");

    // R3: clear alone
    cyc(1'b0, 1'b1, $urandom, 4'b1111, "R3");
    check(crc_o == SEED, "R3", crc_o, SEED);

    // R4: valid and clear together
    cyc(1'b1, 1'b0, 32'h12345678, 4'b1111, "R4");
    cyc(1'b1, 1'b1, 32'hA5A5F00F, 4'b1111, "R4");
    check(crc_o != SEED, "R4", crc_o, model);

    // R9: good frames of every length class, back to back, with clears between
    for (int len = 1; len <= 24; len++) begin
      cyc(1'b0, 1'b1, 32'h0, 4'h0, "R3");
      build_good(len);
      send_frame("R9");
      check(residue_ok_o == 1'b1, "R9", {31'b0, residue_ok_o}, 32'h1);
      check(crc_o == GOOD, "R9", crc_o, GOOD);
    end

    // R9: single-bit corruption must not produce the residue
    for (int t = 0; t < 24; t++) begin
      cyc(1'b0, 1'b1, 32'h0, 4'h0, "R3");
      build_good(1 + ($urandom % 40));
      pos = int'($urandom % (fr_len * 8));
      fr[pos/8][pos%8] = ~fr[pos/8][pos%8];
      send_frame("R9");
      check(residue_ok_o == 1'b0, "R9", {31'b0, residue_ok_o}, 32'h0);
    end

    // R2: reset mid-stream
    cyc(1'b1, 1'b0, $urandom, 4'b1111, "R1");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = SEED;
    check(crc_o == SEED, "R2", crc_o, SEED);
    check(residue_ok_o == 1'b0, "R2", {31'b0, residue_ok_o}, 32'h0);

    report();
  end
endmodule